// File: doc/BRIEF.md
# Latched Four-Bit Adder Slice

This block is the addition step of a small processor datapath. Two operand words are loaded into a level-sensitive operand cache while a write strobe is high. A ripple-carry adder built from pairs of half adders forms their sum. The result reaches a shared data output only while a read strobe is high. A carry flag and a zero flag describe the cached sum at all times.

Each use has three phases. First the operands are loaded by pulsing the write strobe. Then the adder is given time to settle. Last the read strobe is raised to put the result on the output. No separate hardware handles subtraction: a negative operand is supplied in two's complement, and the modulo-16 sum gives the difference.

Top module: `latched_add_unit`

## Requirements
- R1: While `rst_n` is low, both cached operands are cleared, and this overrides a high `wr_en`. After reset and before any write, a read returns 0000 with `zf_out` = 1 and `cf_out` = 0.
- R2: While `wr_en` is high, the cache is transparent. With `rd_en` also high, `data_out` follows the live `op_a` and `op_b` as they change.
- R3: While `wr_en` is low, the cache holds the last values it took. Later changes on `op_a` and `op_b` have no effect on `data_out`, `cf_out` or `zf_out`.
- R4: While `rd_en` is low, `data_out` is 0000 whatever the operands are.
- R5: While `rd_en` is high, `data_out` equals (A + B) mod 16, where A and B are the cached operands read as unsigned numbers.
- R6: `cf_out` is 1 exactly when A + B is 16 or more, that is, when the sum needs a fifth bit.
- R7: `zf_out` is 1 exactly when the four sum bits are all zero. The carry does not count toward it.
- R8: `cf_out` and `zf_out` are valid while `rd_en` is low; the read strobe does not gate them.
- R9: Operands 0011 and 1101 give 0000 with both flags set. Operands 0111 and 1010 give 0001 with `cf_out` = 1 and `zf_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous clear of the operand cache |
| wr_en | input | 1 | Write strobe; cache is transparent while high |
| rd_en | input | 1 | Read strobe; enables the sum onto `data_out` |
| op_a | input | WIDTH (4) | First operand |
| op_b | input | WIDTH (4) | Second operand |
| data_out | output | WIDTH (4) | Gated sum, all zero while `rd_en` is low |
| cf_out | output | 1 | Carry out of the top bit of the cached sum |
| zf_out | output | 1 | High when the cached sum bits are all zero |

## Verification
The bench builds the block with the default `WIDTH` of 4. That leaves only 256 operand pairs, so the bench tries every one of them. Each pair is written, the inputs are then disturbed, and the outputs are read. This covers every carry chain length, every wrap to zero, and every flag combination. Directed steps add the behaviour of reset against a live write, the case where both strobes are high together, and the two fixed operand pairs.

// File: rtl/latched_add_pkg.sv
package latched_add_pkg;
  // One half-adder result: sum bit and carry bit.
  typedef struct packed {
    logic carry;
    logic sum;
  } ha_bits_t;
endpackage

// File: rtl/add_operand_latch.sv
module add_operand_latch #(
  parameter int WIDTH = 4
) (
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  // Level-sensitive cache: transparent while load_en is high, clear wins.
  always_latch begin
    if (!rst_n) begin
      q_out <= '0;
    end else if (load_en) begin
      q_out <= d_in;
    end
  end
endmodule

// File: rtl/add_half_cell.sv
module add_half_cell
  import latched_add_pkg::*;
(
  input  logic     x,
  input  logic     y,
  output ha_bits_t res
);
  always_comb begin
    res.sum   = x ^ y;
    res.carry = x & y;
  end
endmodule

// File: rtl/add_ripple_chain.sv
module add_ripple_chain
  import latched_add_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  localparam int CHAIN_LEN = WIDTH + 1;

  logic [CHAIN_LEN-1:0] rip_c;

  // Bit 0 has no carry in: a single half adder.
  ha_bits_t lsb_res;
  add_half_cell i_lsb (.x(a_in[0]), .y(b_in[0]), .res(lsb_res));
  assign sum_out[0] = lsb_res.sum;
  assign rip_c[1]   = lsb_res.carry;
  assign rip_c[0]   = 1'b0;

  // Upper bits: two chained half adders, carries merged with OR.
  for (genvar k = 1; k < WIDTH; k++) begin : g_bit
    ha_bits_t stage1;
    ha_bits_t stage2;
    add_half_cell i_first  (.x(a_in[k]),    .y(b_in[k]),  .res(stage1));
    add_half_cell i_second (.x(stage1.sum), .y(rip_c[k]), .res(stage2));
    assign sum_out[k]  = stage2.sum;
    assign rip_c[k+1]  = stage1.carry | stage2.carry;
  end

  assign carry_out = rip_c[WIDTH] | rip_c[0];
endmodule

// File: rtl/latched_add_unit.sv
module latched_add_unit #(
  parameter int WIDTH = 4
) (
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] data_out,
  output logic             cf_out,
  output logic             zf_out
);
  logic [WIDTH-1:0] cache_a;
  logic [WIDTH-1:0] cache_b;
  logic [WIDTH-1:0] raw_sum;
  logic             raw_carry;

  add_operand_latch #(.WIDTH(WIDTH)) i_latch_a (
    .rst_n(rst_n), .load_en(wr_en), .d_in(op_a), .q_out(cache_a)
  );
  add_operand_latch #(.WIDTH(WIDTH)) i_latch_b (
    .rst_n(rst_n), .load_en(wr_en), .d_in(op_b), .q_out(cache_b)
  );

  add_ripple_chain #(.WIDTH(WIDTH)) i_adder (
    .a_in(cache_a), .b_in(cache_b), .sum_out(raw_sum), .carry_out(raw_carry)
  );

  // Output gate: every bit ANDed with the read strobe.
  always_comb begin
    data_out = raw_sum & {WIDTH{rd_en}};
    cf_out   = raw_carry;
    zf_out   = ~|raw_sum;
  end
endmodule

// File: rtl/latched_add_unit_chk.sv
module latched_add_unit_chk #(
  parameter int WIDTH = 4
) (
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [WIDTH-1:0] data_out,
  input logic             cf_out,
  input logic             zf_out,
  input logic [WIDTH-1:0] cache_a,
  input logic [WIDTH-1:0] cache_b
);
  logic [WIDTH:0] ref_total;
  always_comb ref_total = {1'b0, cache_a} + {1'b0, cache_b};

  always_comb begin
    if (!rst_n) begin
      a_r1_reset_clears: assert (cache_a == '0 && cache_b == '0);
    end else begin
      if (wr_en) begin
        a_r2_transparent: assert (cache_a == op_a && cache_b == op_b);
      end
      if (!rd_en) begin
        a_r4_gated_low: assert (data_out == '0);
      end else begin
        a_r5_sum_out: assert (data_out == ref_total[WIDTH-1:0]);
      end
      a_r6_carry: assert (cf_out == ref_total[WIDTH]);
      a_r7_zero: assert (zf_out == (ref_total[WIDTH-1:0] == '0));
    end
  end
endmodule

bind latched_add_unit latched_add_unit_chk #(.WIDTH(WIDTH)) i_chk (
  .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .op_a(op_a), .op_b(op_b),
  .data_out(data_out), .cf_out(cf_out), .zf_out(zf_out),
  .cache_a(cache_a), .cache_b(cache_b)
);

// File: tb/test_latched_add_unit.sv
module test_latched_add_unit;
  localparam int W = 4;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 20000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic         rd_en;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic [W-1:0] data_out;
  logic         cf_out;
  logic         zf_out;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  bit done = 0;

  latched_add_unit #(.WIDTH(W)) i_latched_add_unit (
    .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .op_a(op_a), .op_b(op_b),
    .data_out(data_out), .cf_out(cf_out), .zf_out(zf_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b1; rd_en = 1'b1; op_a = 4'd9; op_b = 4'd5;
    // R1: clear dominates a live write
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 data during reset", data_out, 0);
    chk("R1 zf during reset", zf_out, 1);
    chk("R1 cf during reset", cf_out, 0);
    @(posedge clk); wr_en = 1'b0;
    @(posedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 data after reset", data_out, 0);
    chk("R1 zf after reset", zf_out, 1);

    // R2: both strobes high, output tracks live inputs
    @(posedge clk); wr_en = 1'b1; op_a = 4'd2; op_b = 4'd6;
    @(negedge clk);
    chk("R2 live sum 2+6", data_out, 8);
    @(posedge clk); op_a = 4'd15; op_b = 4'd4;
    @(negedge clk);
    chk("R2 live sum 15+4", data_out, 3);
    chk("R2 live carry", cf_out, 1);
    @(posedge clk); wr_en = 1'b0; rd_en = 1'b0;

    // R9: fixed operand pairs
    @(posedge clk); op_a = 4'b0011; op_b = 4'b1101; wr_en = 1'b1;
    @(posedge clk); wr_en = 1'b0; rd_en = 1'b1;
    @(negedge clk);
    chk("R9 3+13 data", data_out, 0);
    chk("R9 3+13 cf", cf_out, 1);
    chk("R9 3+13 zf", zf_out, 1);
    @(posedge clk); op_a = 4'b0111; op_b = 4'b1010; wr_en = 1'b1;
    @(posedge clk); wr_en = 1'b0;
    @(negedge clk);
    chk("R9 7+10 data", data_out, 1);
    chk("R9 7+10 cf", cf_out, 1);
    chk("R9 7+10 zf", zf_out, 0);
    @(posedge clk); rd_en = 1'b0;

    // Exhaustive sweep: R3 R4 R5 R6 R7 R8
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        int tot;
        tot = a + b;
        @(posedge clk); op_a = W'(a); op_b = W'(b); wr_en = 1'b1;
        @(posedge clk); wr_en = 1'b0;
        @(posedge clk); op_a = W'(~a); op_b = W'(b ^ 5);
        @(negedge clk);
        chk("R4 gated output", data_out, 0);
        chk("R6 R8 carry with read low", cf_out, (tot >= 16) ? 1 : 0);
        chk("R7 R8 zero with read low", zf_out, ((tot % 16) == 0) ? 1 : 0);
        @(posedge clk); rd_en = 1'b1;
        @(negedge clk);
        chk("R5 R3 held sum", data_out, tot % 16);
        @(posedge clk); rd_en = 1'b0;
      end
    end

    done = 1;
    finish_run();
  end
endmodule